// File: doc/BRIEF.md
# Real-time clock with deferred register writes

This block is a small real-time clock for a slow timing domain that has been brought onto the system clock as a single-cycle enable. A prescaler divides that raw enable down to one counting tick per second. On every tick the block advances a packed time word (day count, hours, minutes, seconds), runs a countdown stopwatch and compares the new time against an alarm word. Each boundary the clock crosses raises its own event flag. A mask selects which flags drive the single interrupt output.

Software reaches the block through a plain synchronous register port. Writes to the time, alarm, stopwatch, mask and prescaler registers are not applied at once. The block stages one such write and applies it only at the next counting tick. While that write waits, any further deferred write is thrown away, so software must wait for the pending flag to drop before it writes again. The status register is the only exception: writing ones to it clears flags in the same cycle, whether or not a deferred write is waiting.

Register map (addr): 0 time word, 1 alarm word, 2 stopwatch, 3 interrupt mask, 4 status, 5 prescaler enable (bit 0). Addresses 6 and 7 read as zero and ignore writes.

Top module: `rtc_deferred`

## Requirements
- R1: After reset the time, alarm, stopwatch, mask and status all read 0, the prescaler enable reads 1, no write is pending and irq is low.
- R2: A write to address 0, 1, 2, 3 or 5 while nothing is pending is staged and sets status bit 14 (pending) from the next cycle. The target register keeps its old value until the next counting tick. At that tick the value is applied, bit 14 clears and status bit 15 (write complete) sets.
- R3: A deferred write that arrives while bit 14 is set is discarded, and the register it addressed keeps its value after the staged write has been applied.
- R4: Writing the status register (address 4) clears, in the same clock edge, every flag whose data bit is 1, even while a deferred write is pending. Writing 0xFFFF clears every stored flag. Bit 14 follows the pending state and is not changed by such a write. When a flag is set and cleared in the same cycle, the set wins.
- R5: With prescaler enable 1, a counting tick occurs on every DIV-th cycle in which tick_en is high. With it 0, every cycle with tick_en high is a tick.
- R6: The time word holds seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and a 15-bit day count in bits 31:17. Each counting tick sets status bit 2 and advances the seconds. When seconds of 59 or more wrap to 0, minutes advance and bit 3 is set. When minutes of 59 or more wrap, hours advance and bit 4 is set. When hours of 23 or more wrap, the day count advances modulo 2^15 and bit 5 is set.
- R7: On each tick, when bits 16:0 of the new time equal those of the alarm word held before the tick, status bit 1 is set.
- R8: On each tick, when all 32 bits of the new time equal the alarm word held before the tick, status bit 6 is set.
- R9: On each tick a nonzero stopwatch decrements by one. Its step from 1 to 0 sets status bit 0. At 0 it stays at 0.
- R10: The mask (address 3) keeps only bits 15, 14 and 6:0, in the same positions as the status bits. irq is high exactly when some status bit and the mask bit at the same position are both 1.
- R11: On the tick that applies a staged time or stopwatch write, that register takes the written value without counting, and the counting events of bits 2 to 5 and bit 0 are not raised by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Raw slow-clock enable, one cycle per slow-clock period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DIV set to 4 and the default 16-bit stopwatch. That puts a counting tick every four raw enables, so staged writes, dropped second writes and status clears can all be observed around the tick edge within a few cycles. The short division also lets directed runs cross the 23:59:59 day boundary and hit both alarm kinds, and lets thousands of random enable and write patterns reach many commits. One check switches the prescaler off and shows that every raw enable then counts.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // status / mask bit positions
  localparam int BIT_DONE = 15;
  localparam int BIT_PEND = 14;
  localparam int BIT_DALM = 6;
  localparam int BIT_DAY  = 5;
  localparam int BIT_HOUR = 4;
  localparam int BIT_MIN  = 3;
  localparam int BIT_SEC  = 2;
  localparam int BIT_ALM  = 1;
  localparam int BIT_SW   = 0;

  localparam int NEVT = 7;
  localparam logic [15:0] MASK_KEEP = 16'hC07F;

  localparam logic [2:0] A_TIME  = 3'd0;
  localparam logic [2:0] A_ALARM = 3'd1;
  localparam logic [2:0] A_SWCH  = 3'd2;
  localparam logic [2:0] A_MASK  = 3'd3;
  localparam logic [2:0] A_STAT  = 3'd4;
  localparam logic [2:0] A_PSC   = 3'd5;

  typedef struct packed {
    logic [14:0] day;
    logic [4:0]  hour;
    logic [5:0]  min;
    logic [5:0]  sec;
  } tword_t;

  function automatic logic is_deferred(logic [2:0] a);
    return (a == A_TIME) || (a == A_ALARM) || (a == A_SWCH) ||
           (a == A_MASK) || (a == A_PSC);
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_en,
  input  logic scale_on,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = raw_en && (!scale_on || (cnt_q == LAST));

  always_comb begin
    cnt_d = cnt_q;
    if (raw_en) begin
      if (tick) cnt_d = '0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_stage.sv
module rtc_stage #(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          tick,
  output logic          pending,
  output logic          commit,
  output logic [AW-1:0] c_addr,
  output logic [DW-1:0] c_data
);
  import rtc_pkg::*;

  logic          pend_q, pend_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          accept;

  assign accept  = wr_en && is_deferred(3'(wr_addr)) && !pend_q;
  assign commit  = tick && pend_q;
  assign pending = pend_q;
  assign c_addr  = addr_q;
  assign c_data  = data_q;

  always_comb begin
    pend_d = pend_q;
    addr_d = addr_q;
    data_d = data_q;
    if (commit) begin
      pend_d = 1'b0;
    end else if (accept) begin
      pend_d = 1'b1;
      addr_d = wr_addr;
      data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      pend_q <= pend_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/rtc_timekeep.sv
module rtc_timekeep #(
  parameter int SW_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    load_time,
  input  logic                    load_sw,
  input  logic [31:0]             load_val,
  input  logic [31:0]             alarm,
  output logic [31:0]             time_word,
  output logic [SW_W-1:0]         sw_count,
  output logic [rtc_pkg::NEVT-1:0] events
);
  import rtc_pkg::*;

  tword_t         t_q, t_d;
  logic [SW_W-1:0] sw_q, sw_d;

  assign time_word = t_q;
  assign sw_count  = sw_q;

  always_comb begin
    t_d    = t_q;
    sw_d   = sw_q;
    events = '0;
    if (tick) begin
      if (load_time) begin
        t_d = tword_t'(load_val);
      end else begin
        events[BIT_SEC] = 1'b1;
        if (t_q.sec >= 6'd59) begin
          t_d.sec = '0;
          events[BIT_MIN] = 1'b1;
          if (t_q.min >= 6'd59) begin
            t_d.min = '0;
            events[BIT_HOUR] = 1'b1;
            if (t_q.hour >= 5'd23) begin
              t_d.hour = '0;
              t_d.day  = t_q.day + 1'b1;
              events[BIT_DAY] = 1'b1;
            end else begin
              t_d.hour = t_q.hour + 1'b1;
            end
          end else begin
            t_d.min = t_q.min + 1'b1;
          end
        end else begin
          t_d.sec = t_q.sec + 1'b1;
        end
      end
      events[BIT_ALM]  = (t_d[16:0] == alarm[16:0]);
      events[BIT_DALM] = (t_d == alarm);

      if (load_sw) begin
        sw_d = load_val[SW_W-1:0];
      end else if (sw_q != '0) begin
        sw_d = sw_q - 1'b1;
        events[BIT_SW] = (sw_q == SW_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q  <= '0;
      sw_q <= '0;
    end else begin
      t_q  <= t_d;
      sw_q <= sw_d;
    end
  end
endmodule

// File: rtl/rtc_deferred.sv
module rtc_deferred #(
  parameter int DIV  = 32768,
  parameter int SW_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        irq
);
  import rtc_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  logic            tick, pend, commit;
  logic [2:0]      stg_addr;
  logic [31:0]     stg_data;
  logic [31:0]     time_w;
  logic [SW_W-1:0] sw_q;
  logic [NEVT-1:0] evt;

  logic            psc_on_q, psc_on_d;
  logic [31:0]     alarm_q, alarm_d;
  logic [15:0]     mask_q, mask_d;
  logic            done_q, done_d;
  logic [NEVT-1:0] flag_q, flag_d;
  logic [15:0]     clr;
  logic [15:0]     stat_w;

  rtc_prescaler #(.DIV(DIV)) u_psc (
    .clk(clk), .rst_n(srst_n), .raw_en(tick_en), .scale_on(psc_on_q), .tick(tick)
  );

  rtc_stage #(.AW(3), .DW(32)) u_stage (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_addr(addr), .wr_data(wr_data),
    .tick(tick), .pending(pend), .commit(commit), .c_addr(stg_addr), .c_data(stg_data)
  );

  rtc_timekeep #(.SW_W(SW_W)) u_tk (
    .clk(clk), .rst_n(srst_n), .tick(tick),
    .load_time(commit && (stg_addr == A_TIME)),
    .load_sw(commit && (stg_addr == A_SWCH)),
    .load_val(stg_data), .alarm(alarm_q),
    .time_word(time_w), .sw_count(sw_q), .events(evt)
  );

  always_comb begin
    clr = (wr_en && (addr == A_STAT)) ? wr_data[15:0] : 16'h0000;
    flag_d = (flag_q & ~clr[NEVT-1:0]) | evt;
    done_d = (done_q & ~clr[BIT_DONE]) | commit;
    alarm_d  = alarm_q;
    mask_d   = mask_q;
    psc_on_d = psc_on_q;
    if (commit) begin
      case (stg_addr)
        A_ALARM: alarm_d  = stg_data;
        A_MASK:  mask_d   = stg_data[15:0] & MASK_KEEP;
        A_PSC:   psc_on_d = stg_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      alarm_q  <= '0;
      mask_q   <= '0;
      psc_on_q <= 1'b1;
      done_q   <= 1'b0;
      flag_q   <= '0;
    end else begin
      alarm_q  <= alarm_d;
      mask_q   <= mask_d;
      psc_on_q <= psc_on_d;
      done_q   <= done_d;
      flag_q   <= flag_d;
    end
  end

  always_comb begin
    stat_w = 16'h0000;
    stat_w[NEVT-1:0] = flag_q;
    stat_w[BIT_PEND] = pend;
    stat_w[BIT_DONE] = done_q;
  end

  assign irq = |(stat_w & mask_q);

  always_comb begin
    case (addr)
      A_TIME:  rd_data = time_w;
      A_ALARM: rd_data = alarm_q;
      A_SWCH:  rd_data = 32'(sw_q);
      A_MASK:  rd_data = {16'h0000, mask_q};
      A_STAT:  rd_data = {16'h0000, stat_w};
      A_PSC:   rd_data = {31'h0, psc_on_q};
      default: rd_data = 32'h0;
    endcase
  end
endmodule

// File: rtl/rtc_deferred_chk.sv
module rtc_deferred_chk #(
  parameter int SW_W = 16
) (
  input logic            clk,
  input logic            srst_n,
  input logic            tick_en,
  input logic            tick,
  input logic            psc_on,
  input logic            wr_en,
  input logic [2:0]      addr,
  input logic [31:0]     wr_data,
  input logic            pend,
  input logic            commit,
  input logic [2:0]      stg_addr,
  input logic [31:0]     stg_data,
  input logic            done,
  input logic [6:0]      flag,
  input logic [SW_W-1:0] sw,
  input logic [15:0]     mask,
  input logic            irq
);
  // R2
  accept_sets_pend_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && addr != 3'd4 && addr <= 3'd5 && !pend) |=> pend);

  // R3
  staged_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (pend && !tick) |=> (pend && $stable(stg_data) && $stable(stg_addr)));

  // R2
  commit_done_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (pend && tick) |=> (!pend && done));

  // R4
  done_clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && addr == 3'd4 && wr_data[15] && !commit) |=> !done);

  // R5
  raw_rate_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (tick_en && !psc_on) |-> tick);

  // R9
  sw_expire_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (tick && !(commit && stg_addr == 3'd2) && sw == SW_W'(1)) |=> (sw == '0 && flag[0]));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> (((mask[6:0] & flag) != 7'd0) || (mask[15] && done) || (mask[14] && pend)));
endmodule

bind rtc_deferred rtc_deferred_chk #(.SW_W(SW_W)) u_chk (
  .clk(clk), .srst_n(srst_n), .tick_en(tick_en), .tick(tick), .psc_on(psc_on_q),
  .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .pend(pend), .commit(commit),
  .stg_addr(stg_addr), .stg_data(stg_data), .done(done_q), .flag(flag_q),
  .sw(sw_q), .mask(mask_q), .irq(irq)
);

// File: tb/rtc_deferred_test.sv
module rtc_deferred_test;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, wr_en;
  logic [2:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        irq;

  rtc_deferred #(.DIV(DIV), .SW_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  // reference state built from the requirements
  int          m_pc;
  bit          m_psc, m_pend, m_done;
  logic [31:0] m_time, m_alarm, m_pdata;
  logic [15:0] m_sw, m_mask;
  logic [6:0]  m_flag;
  logic [2:0]  m_paddr;
  int          m_ticks;

  function automatic logic [31:0] pack(int d, int h, int m, int s);
    logic [31:0] w;
    w = 32'h0;
    w[31:17] = d[14:0];
    w[16:12] = h[4:0];
    w[11:6]  = m[5:0];
    w[5:0]   = s[5:0];
    return w;
  endfunction

  function automatic logic [15:0] m_stat();
    return {m_done, m_pend, 7'b0, m_flag};
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_time;
      3'd1: return m_alarm;
      3'd2: return {16'h0, m_sw};
      3'd3: return {16'h0, m_mask};
      3'd4: return {16'h0, m_stat()};
      3'd5: return {31'h0, m_psc};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0: return "R6";
      3'd1: return "R7";
      3'd2: return "R9";
      3'd3: return "R10";
      3'd4: return "R4";
      3'd5: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(bit en, bit we, logic [2:0] a, logic [31:0] d);
    bit tick, commit, accept;
    logic [6:0]  ev;
    logic [15:0] clr;
    logic [31:0] nt;
    int s, mn, hr, dy;
    tick   = en && (!m_psc || m_pc == DIV - 1);
    commit = tick && m_pend;
    accept = we && (a == 3'd0 || a == 3'd1 || a == 3'd2 || a == 3'd3 || a == 3'd5) && !m_pend;
    clr    = (we && a == 3'd4) ? d[15:0] : 16'h0;
    ev     = 7'h0;
    if (en) m_pc = tick ? 0 : m_pc + 1;
    if (tick) begin
      m_ticks++;
      if (commit && m_paddr == 3'd0) begin
        nt = m_pdata;
      end else begin
        s = m_time[5:0]; mn = m_time[11:6]; hr = m_time[16:12]; dy = m_time[31:17];
        ev[2] = 1;
        s = s + 1;
        if (s >= 60) begin
          s = 0; ev[3] = 1; mn = mn + 1;
          if (mn >= 60) begin
            mn = 0; ev[4] = 1; hr = hr + 1;
            if (hr >= 24) begin
              hr = 0; ev[5] = 1; dy = (dy + 1) % 32768;
            end
          end
        end
        nt = pack(dy, hr, mn, s);
      end
      ev[1] = (nt[16:0] == m_alarm[16:0]);
      ev[6] = (nt == m_alarm);
      m_time = nt;
      if (commit && m_paddr == 3'd2) m_sw = m_pdata[15:0];
      else if (m_sw != 0) begin
        if (m_sw == 16'd1) ev[0] = 1;
        m_sw = m_sw - 1;
      end
    end
    if (commit) begin
      if (m_paddr == 3'd1) m_alarm = m_pdata;
      if (m_paddr == 3'd3) m_mask = m_pdata[15:0] & 16'hC07F;
      if (m_paddr == 3'd5) m_psc = m_pdata[0];
    end
    m_flag = (m_flag & ~clr[6:0]) | ev;
    m_done = (m_done & ~clr[15]) | commit;
    if (commit) m_pend = 0;
    else if (accept) begin
      m_pend = 1; m_paddr = a; m_pdata = d;
    end
  endtask

  task automatic step(bit en, bit we, logic [2:0] a, logic [31:0] d);
    logic [15:0] st;
    @(negedge clk);
    tick_en = en; wr_en = we; addr = a; wr_data = d;
    #1;
    check(rd_data == m_read(a), tag_of(a), rd_data, m_read(a));
    st = m_stat();
    check(irq == |(st & m_mask), "R10", {31'h0, irq}, {31'h0, |(st & m_mask)});
    model_step(en, we, a, d);
  endtask

  task automatic peek(logic [2:0] a, logic [31:0] mask, logic [31:0] exp, string tag);
    @(negedge clk);
    tick_en = 0; wr_en = 0; addr = a; wr_data = 0;
    #1;
    check((rd_data & mask) == exp, tag, rd_data & mask, exp);
    model_step(0, 0, a, 0);
  endtask

  task automatic run_ticks(int n);
    int target;
    target = m_ticks + n;
    while (m_ticks < target) step(1, 0, 3'd0, 0);
  endtask

  task automatic write_wait(logic [2:0] a, logic [31:0] d);
    step(0, 1, a, d);
    run_ticks(1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  initial begin
    rst_n = 0; tick_en = 0; wr_en = 0; addr = 0; wr_data = 0;
    m_pc = 0; m_psc = 1; m_pend = 0; m_done = 0; m_time = 0; m_alarm = 0;
    m_pdata = 0; m_sw = 0; m_mask = 0; m_flag = 0; m_paddr = 0; m_ticks = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    peek(3'd0, 32'hFFFFFFFF, 32'h0, "R1");
    peek(3'd1, 32'hFFFFFFFF, 32'h0, "R1");
    peek(3'd2, 32'hFFFFFFFF, 32'h0, "R1");
    peek(3'd3, 32'hFFFFFFFF, 32'h0, "R1");
    peek(3'd4, 32'hFFFFFFFF, 32'h0, "R1");
    peek(3'd5, 32'hFFFFFFFF, 32'h1, "R1");
    check(irq == 1'b0, "R1", {31'h0, irq}, 32'h0);

    // R7 time-of-day alarm, R10 irq
    write_wait(3'd0, pack(2, 10, 20, 30));
    write_wait(3'd1, pack(7, 10, 20, 33));
    write_wait(3'd3, 32'h0000_0002);
    run_ticks(1);
    peek(3'd4, 32'h42, 32'h02, "R7");
    check(irq == 1'b1, "R10", {31'h0, irq}, 32'h1);

    // R8 full-word alarm
    step(0, 1, 3'd4, 32'hFFFF);
    write_wait(3'd1, pack(2, 10, 20, 36));
    run_ticks(2);
    peek(3'd4, 32'h42, 32'h42, "R8");

    // R11 staged time loads as written; R6 rollover across the day
    write_wait(3'd0, pack(5, 23, 59, 58));
    peek(3'd0, 32'hFFFFFFFF, pack(5, 23, 59, 58), "R11");
    step(0, 1, 3'd4, 32'hFFFF);
    run_ticks(1);
    peek(3'd4, 32'h3C, 32'h04, "R6");
    run_ticks(1);
    peek(3'd0, 32'hFFFFFFFF, pack(6, 0, 0, 0), "R6");
    peek(3'd4, 32'h3C, 32'h3C, "R6");

    // R9 stopwatch
    write_wait(3'd2, 32'd3);
    peek(3'd2, 32'hFFFFFFFF, 32'd3, "R11");
    run_ticks(2);
    step(0, 1, 3'd4, 32'hFFFF);
    peek(3'd4, 32'h01, 32'h00, "R9");
    run_ticks(1);
    peek(3'd2, 32'hFFFFFFFF, 32'd0, "R9");
    peek(3'd4, 32'h01, 32'h01, "R9");
    step(0, 1, 3'd4, 32'hFFFF);
    run_ticks(1);
    peek(3'd2, 32'hFFFFFFFF, 32'd0, "R9");
    peek(3'd4, 32'h01, 32'h00, "R9");

    // R2 staging and commit, R3 drop of second write
    step(0, 1, 3'd0, pack(1, 2, 3, 4));
    peek(3'd4, 32'hC000, 32'h4000, "R2");
    peek(3'd0, 32'hFFFFFFFF, m_time, "R2");
    step(0, 1, 3'd1, 32'h0001_2345);
    run_ticks(1);
    peek(3'd4, 32'hC000, 32'h8000, "R2");
    peek(3'd0, 32'hFFFFFFFF, pack(1, 2, 3, 4), "R2");
    peek(3'd1, 32'hFFFFFFFF, pack(2, 10, 20, 36), "R3");

    // R4 immediate clear while pending
    step(0, 1, 3'd2, 32'd9);
    step(0, 1, 3'd4, 32'hFFFF);
    peek(3'd4, 32'hFFFF, 32'h4000, "R4");
    run_ticks(1);

    // R5 prescaler off: every raw enable counts
    write_wait(3'd5, 32'h0);
    write_wait(3'd0, pack(0, 0, 0, 0));
    repeat (5) step(1, 0, 3'd0, 0);
    peek(3'd0, 32'hFFFFFFFF, pack(0, 0, 0, 5), "R5");
    write_wait(3'd5, 32'h1);
    peek(3'd5, 32'hFFFFFFFF, 32'h1, "R5");

    // random mix checked against the reference each cycle
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      bit en, we;
      logic [2:0]  a;
      logic [31:0] d;
      en = ($urandom % 2) == 0;
      we = ($urandom % 4) == 0;
      a  = 3'($urandom % 8);
      d  = $urandom;
      if (a == 3'd5 && ($urandom % 4) != 0) d[0] = 1'b1;
      if (a == 3'd0) d = pack($urandom % 32768, $urandom % 24, $urandom % 60, 50 + $urandom % 10);
      if (a == 3'd2) d = $urandom % 6;
      step(en, we, a, d);
    end

    summary();
  end
endmodule